// File: doc/BRIEF.md
# Nine-bit FIFO with read rewind and half-full flag

This block is a single-clock first-in/first-out buffer for 9-bit words, so a ninth bit can travel alongside each byte as parity or a control marker. Depth is a parameter and may be 256, 512 or 1024 words. The producer presents a word and pulses a write strobe. The consumer pulses a read strobe and finds the word on a registered output one clock later. Neither side gives an address: each side advances its own ring pointer.

Three active-low flags report the fill state: empty, full, and more-than-half-full. An active-low rewind input returns the read pointer to storage location zero and leaves the write pointer where it is, so the data stored since reset can be read out a second time. This is useful, for example, to resend a frame after the far end reports an error. The flags are recomputed from the rewound pointer. Rewind is meaningful as long as no more than DEPTH words have been written since reset. An active-low asynchronous reset clears both pointers.

Top module: `fifo9_rt`

## Requirements
- R1: While reset is low and on the first clock after it is released, empty_n is 0, full_n is 1, half_n is 1 and rd_data is 0. Both pointers are at location zero, so the first word written after reset is the first word read.
- R2: Words are read out in the order they were written, with all 9 bits intact.
- R3: A write strobe while full_n is 0 is ignored. No storage is overwritten and the rejected word never appears on rd_data.
- R4: A read strobe while empty_n is 0 is ignored. rd_data holds its value and the flags do not change.
- R5: full_n is 0 exactly when the stored word count equals DEPTH.
- R6: empty_n is 0 exactly when the stored word count is 0.
- R7: half_n is 0 exactly when the stored word count is greater than DEPTH/2. At a count of exactly DEPTH/2 it is 1.
- R8: A read and a write accepted in the same cycle leave the word count, and so all three flags, unchanged.
- R9: A clock edge with rt_n at 0 (and reset high) sets the read pointer to location zero and leaves the write pointer unchanged. Read and write strobes in that cycle are ignored. The flags are then recomputed as the words written since reset, and the next reads return those words from the first one on.
- R10: rd_data is a register. It changes only on the clock edge that accepts a read, and then takes the word being read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; clears both pointers |
| wr_en | input | 1 | Write strobe, active high |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read strobe, active high |
| rt_n | input | 1 | Rewind read pointer to location zero, active low |
| rd_data | output | WIDTH | Registered word from the last accepted read |
| empty_n | output | 1 | Low when no words are stored |
| full_n | output | 1 | Low when DEPTH words are stored |
| half_n | output | 1 | Low when more than DEPTH/2 words are stored |

## Verification
The hardest state to reach is a rewind issued while the buffer is full and part of it has already been read out. There the rewound count returns to DEPTH, full must come back, and the rejected overflow word must never show up. The directed phase fills the buffer to the last slot, hammers the write strobe while full, reads a few words, and rewinds. It then drains everything and checks that the original sequence replays from word zero. A constrained-random phase with a fixed seed follows. It mixes strobes, allows rewinds only while no more than DEPTH words have been written since reset, and inserts mid-stream resets. Each cycle is compared against a queue model that the bench computes.

// File: rtl/fifo9_pkg.sv
`timescale 1ns/1ps
package fifo9_pkg;
   localparam int unsigned FIFO9_DEF_WIDTH = 9;
   localparam int unsigned FIFO9_DEF_DEPTH = 1024;

   function automatic bit depth_ok(input int unsigned d);
      return (d == 256) || (d == 512) || (d == 1024);
   endfunction
endpackage

// File: rtl/fifo9_ptr.sv
`timescale 1ns/1ps
module fifo9_ptr #(
   parameter int unsigned PW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic          rewind,
   output logic [PW-1:0] ptr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr <= '0;
      else if (rewind)  ptr <= '0;
      else if (adv)     ptr <= ptr + PW'(1);
   end
endmodule

// File: rtl/fifo9_ram.sv
`timescale 1ns/1ps
module fifo9_ram #(
   parameter int unsigned WIDTH = 9,
   parameter int unsigned DEPTH = 1024,
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             re,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rdata <= '0;
      else if (re)  rdata <= store[raddr];
   end
endmodule

// File: rtl/fifo9_flags.sv
`timescale 1ns/1ps
module fifo9_flags #(
   parameter int unsigned DEPTH = 1024,
   localparam int unsigned PW = $clog2(DEPTH) + 1
) (
   input  logic [PW-1:0] wptr,
   input  logic [PW-1:0] rptr,
   output logic          empty_n,
   output logic          full_n,
   output logic          half_n
);
   localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
   localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);

   logic [PW-1:0] fill;

   always_comb begin
      fill    = wptr - rptr;
      empty_n = (fill != '0);
      full_n  = (fill != FULL_CNT);
      half_n  = !(fill > HALF_CNT);
   end
endmodule

// File: rtl/fifo9_rt.sv
`timescale 1ns/1ps
module fifo9_rt #(
   parameter int unsigned WIDTH = fifo9_pkg::FIFO9_DEF_WIDTH,
   parameter int unsigned DEPTH = fifo9_pkg::FIFO9_DEF_DEPTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   input  logic             rt_n,
   output logic [WIDTH-1:0] rd_data,
   output logic             empty_n,
   output logic             full_n,
   output logic             half_n
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned PW = AW + 1;

   if (!fifo9_pkg::depth_ok(DEPTH)) begin : g_bad_depth
      $error("fifo9_rt: DEPTH must be 256, 512 or 1024");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("fifo9_rt: WIDTH must be at least 1");
   end

   logic [PW-1:0] wptr, rptr;
   logic          wr_go, rd_go, rewind;

   always_comb begin
      rewind = !rt_n;
      wr_go  = wr_en && full_n  && rt_n;
      rd_go  = rd_en && empty_n && rt_n;
   end

   fifo9_ptr #(.PW(PW)) u_wptr (
      .clk(clk), .rst_n(rst_n), .adv(wr_go), .rewind(1'b0), .ptr(wptr)
   );

   fifo9_ptr #(.PW(PW)) u_rptr (
      .clk(clk), .rst_n(rst_n), .adv(rd_go), .rewind(rewind), .ptr(rptr)
   );

   fifo9_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
      .clk(clk), .rst_n(rst_n),
      .we(wr_go), .waddr(wptr[AW-1:0]), .wdata(wr_data),
      .re(rd_go), .raddr(rptr[AW-1:0]), .rdata(rd_data)
   );

   fifo9_flags #(.DEPTH(DEPTH)) u_flags (
      .wptr(wptr), .rptr(rptr),
      .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
   );
endmodule

// File: rtl/fifo9_rt_chk.sv
`timescale 1ns/1ps
module fifo9_rt_chk #(
   parameter int unsigned WIDTH = 9,
   parameter int unsigned DEPTH = 1024
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             rd_en,
   input logic             rt_n,
   input logic [WIDTH-1:0] rd_data,
   input logic             empty_n,
   input logic             full_n,
   input logic             half_n
);
   assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!empty_n && full_n && half_n && rd_data == '0));

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!full_n && wr_en && !rd_en && rt_n) |=> !full_n);

   assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty_n && rd_en && !wr_en && rt_n) |=> (!empty_n && $stable(rd_data)));

   assert_not_full_and_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(!empty_n && !full_n));

   assert_half_implies_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !half_n |-> empty_n);

   assert_rw_keeps_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_n && full_n && wr_en && rd_en && rt_n) |=> $stable({empty_n, full_n, half_n}));

   assert_rewind_holds_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rt_n |=> $stable(rd_data));

   assert_rdata_only_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && empty_n && rt_n) |=> $stable(rd_data));
endmodule

bind fifo9_rt fifo9_rt_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_fifo9_rt.sv
`timescale 1ns/1ps
module tb_fifo9_rt;
   localparam int unsigned W = 9;
   localparam int unsigned D = 256;
   localparam int unsigned WD_CYCLES = 100000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic         rd_en = 1'b0;
   logic         rt_n = 1'b1;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] rd_data;
   logic         empty_n, full_n, half_n;

   int n_cmp = 0;
   int n_bad = 0;

   logic [W-1:0] mmem [D];
   int           wp = 0;
   int           rp = 0;
   logic [W-1:0] exp_q = '0;

   always #2.5 clk = ~clk;

   fifo9_rt #(.WIDTH(W), .DEPTH(D)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rt_n(rt_n), .rd_data(rd_data),
      .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
   );

   function automatic int fill();
      return wp - rp;
   endfunction

   function automatic logic exp_empty_n();
      return (fill() != 0);
   endfunction

   function automatic logic exp_full_n();
      return (fill() != D);
   endfunction

   function automatic logic exp_half_n();
      return !(fill() > D / 2);
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic check_all();
      chk("R6 empty_n", int'(empty_n), int'(exp_empty_n()));
      chk("R5 full_n", int'(full_n), int'(exp_full_n()));
      chk("R7 half_n", int'(half_n), int'(exp_half_n()));
      chk("R10 rd_data", int'(rd_data), int'(exp_q));
   endtask

   task automatic step(input logic w, input logic r, input logic rt, input logic [W-1:0] d);
      logic wa, ra;
      wr_en = w; rd_en = r; rt_n = !rt; wr_data = d;
      @(posedge clk);
      if (rt) begin
         rp = 0;
      end else begin
         wa = w && (fill() < D);
         ra = r && (fill() > 0);
         if (ra) begin
            exp_q = mmem[rp % D];
            rp++;
         end
         if (wa) begin
            mmem[wp % D] = d;
            wp++;
         end
      end
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0; rt_n = 1'b1;
      check_all();
   endtask

   task automatic do_reset();
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0; rt_n = 1'b1;
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      wp = 0; rp = 0; exp_q = '0;
      chk("R1 empty_n in reset", int'(empty_n), 0);
      chk("R1 full_n in reset", int'(full_n), 1);
      chk("R1 half_n in reset", int'(half_n), 1);
      chk("R1 rd_data in reset", int'(rd_data), 0);
      rst_n = 1'b1;
   endtask

   function automatic logic [W-1:0] pat(input int i);
      return W'((i * 37 + 5) ^ (i >> 3));
   endfunction

   initial begin : watchdog
      repeat (WD_CYCLES) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", WD_CYCLES);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      logic [W-1:0] held;
      void'($urandom(32'd20240611));
      do_reset();

      // R1: first word written after reset is the first word read
      step(1'b1, 1'b0, 1'b0, 9'h1A5);
      step(1'b0, 1'b1, 1'b0, '0);
      chk("R1 first word after reset", int'(rd_data), 'h1A5);
      chk("R6 empty after single round trip", int'(empty_n), 0);

      // R4: read while empty is ignored
      held = rd_data;
      step(1'b0, 1'b1, 1'b0, '0);
      chk("R4 rd_data held on empty read", int'(rd_data), int'(held));
      chk("R4 still empty", int'(empty_n), 0);

      // fill to exactly half, then one more (R7), then to full (R5)
      do_reset();
      for (int i = 0; i < D / 2; i++) step(1'b1, 1'b0, 1'b0, pat(i));
      chk("R7 half_n high at exactly half", int'(half_n), 1);
      step(1'b1, 1'b0, 1'b0, pat(D / 2));
      chk("R7 half_n low above half", int'(half_n), 0);
      for (int i = D / 2 + 1; i < D; i++) step(1'b1, 1'b0, 1'b0, pat(i));
      chk("R5 full_n low at DEPTH", int'(full_n), 0);

      // R3: writes while full are ignored
      for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 9'h0F0);
      chk("R3 full stays after rejected writes", int'(full_n), 0);

      // R9: read a few, rewind mid-stream while simultaneously strobing
      for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b0, '0);
      chk("R2 tenth word in order", int'(rd_data), int'(pat(9)));
      chk("R5 not full after reads", int'(full_n), 1);
      held = rd_data;
      step(1'b1, 1'b1, 1'b1, 9'h0F0);
      chk("R9 full again after rewind", int'(full_n), 0);
      chk("R9 rd_data untouched by rewind", int'(rd_data), int'(held));
      step(1'b0, 1'b1, 1'b0, '0);
      chk("R9 replay starts at word zero", int'(rd_data), int'(pat(0)));

      // drain everything, verifying order; rejected 0F0 never appears (R3)
      for (int i = 1; i < D; i++) begin
         step(1'b0, 1'b1, 1'b0, '0);
         chk("R2 drain order", int'(rd_data), int'(pat(i)));
      end
      chk("R6 empty after drain", int'(empty_n), 0);

      // R8: simultaneous read and write keeps count
      do_reset();
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, pat(100 + i));
      for (int i = 0; i < 20; i++) begin
         step(1'b1, 1'b1, 1'b0, pat(200 + i));
         chk("R8 count unchanged on read+write", fill(), 5);
      end

      // constrained random with occasional resets and legal rewinds
      do_reset();
      for (int c = 0; c < 4000; c++) begin
         int unsigned roll;
         logic w, r, rt;
         roll = $urandom_range(99);
         if (roll == 0) begin
            do_reset();
         end else begin
            rt = (roll == 1) && (wp <= D);
            w  = ($urandom_range(99) < ((c / 500) % 2 == 0 ? 70 : 35));
            r  = ($urandom_range(99) < ((c / 500) % 2 == 0 ? 35 : 70));
            step(w, r, rt, W'($urandom));
         end
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule